// File: doc/BRIEF.md
# BCD Time-of-Day and Day Counter with Alarm

This block keeps wall-clock time from a one-pulse-per-second tick. Seconds, minutes and hours run as two-digit BCD values, and a binary day counter of parameterised width (15 bits by default) advances each time the hours roll past 23. Software reaches every field through a byte-wide register port. Time fields are written one byte at a time, and the count only moves while a run bit in the control register is set.

An alarm holds its own BCD minute and hour values and a binary day value. Each of the three has its own compare-enable bit. On every tick the alarm compares the freshly updated time against the stored values. It fires when the new seconds are zero and every enabled field is equal. Firing sets a sticky flag, which software clears by writing a one to it. The interrupt output mirrors the flag when the interrupt enable is set.

A busy bit in the control register is raised in the cycle that applies a tick and in the cycle after it. Software polls this bit before each access. Register writes that arrive while busy is high are dropped, so a tick never races a software update.

Top module: `bcd_rtc_core`

## Requirements
- R1: Seconds (address 0x15) and minutes (0x16) count in BCD from 0x00 to 0x59. Each wraps to 0x00 and carries into the next field only when it wraps.
- R2: Hours (0x17) count in BCD from 0x00 to 0x23. A wrap from 23:59:59 increments the day count.
- R3: The day count is binary, with its low byte at 0x18 and its upper bits at 0x19. It wraps from its maximum (0x7FFF by default) to 0.
- R4: Field registers read back what was last written or counted. Writing 0x19 keeps only the bits that fit the day width, so bit 7 reads 0 by default. The alarm registers are minute 0x1A, hour 0x1B, day-low 0x1C and day-high 0x1D. Any unmapped address reads 0x00. Reset clears every register.
- R5: The counter advances by one second on a tick pulse only while run (control 0x14 bit 0) is 1. With run at 0, ticks leave the time unchanged.
- R6: Control 0x14 holds bit 5 day-compare enable, bit 4 hour-compare enable, bit 3 minute-compare enable, bit 2 alarm flag, bit 1 interrupt enable and bit 0 run. Bits 6 and 7 are not writable. The alarm flag stays set until a control write with bit 2 = 1. A control write with bit 2 = 0 leaves the flag set.
- R7: Control bit 7 (busy) reads 1 in the cycle a tick is applied (tick high with run set) and in the following cycle, and 0 otherwise. A tick with run at 0 does not raise busy.
- R8: A register write made while busy reads 1 is discarded.
- R9: On each applied tick, the alarm flag is set when the updated seconds are 0x00 and every enabled field equals its alarm value. A tick whose updated seconds are not zero, or a tick with an enabled field that differs, does not set the flag.
- R10: The interrupt output equals the alarm flag ANDed with the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq | output | 1 | Alarm interrupt, flag AND interrupt enable |

## Verification
The rollover assertions assume that software only loads legal BCD time values, since an illegal digit would step through non-time codes. The random stimulus therefore builds every seconds, minutes and hours value from a binary number in range, and biases it toward 0x59 and 0x23 so that the carry chain and the day wrap are reached often. The write-drop and busy assertions assume that tick pulses last one cycle. The bench drives each tick for a single cycle and leaves at least one idle cycle before the next.

// File: rtl/bca_pkg.sv
package bca_pkg;
   // register map
   localparam logic [7:0] A_CTRL   = 8'h14;
   localparam logic [7:0] A_SEC    = 8'h15;
   localparam logic [7:0] A_MIN    = 8'h16;
   localparam logic [7:0] A_HOUR   = 8'h17;
   localparam logic [7:0] A_DAYLO  = 8'h18;
   localparam logic [7:0] A_DAYHI  = 8'h19;
   localparam logic [7:0] A_AMIN   = 8'h1A;
   localparam logic [7:0] A_AHOUR  = 8'h1B;
   localparam logic [7:0] A_ADAYLO = 8'h1C;
   localparam logic [7:0] A_ADAYHI = 8'h1D;

   // control bit positions
   localparam int B_BUSY  = 7;
   localparam int B_DAYEN = 5;
   localparam int B_HREN  = 4;
   localparam int B_MNEN  = 3;
   localparam int B_FLAG  = 2;
   localparam int B_IEN   = 1;
   localparam int B_RUN   = 0;

   // number of BCD stages: seconds, minutes, hours
   localparam int NUM_BCD = 3;

   // plain BCD +1 on two digits (limit handled by caller)
   function automatic logic [7:0] bcd_step(input logic [7:0] v);
      if (v[3:0] >= 4'd9) bcd_step = {v[7:4] + 4'd1, 4'd0};
      else                bcd_step = {v[7:4], v[3:0] + 4'd1};
   endfunction
endpackage

// File: rtl/bca_time_core.sv
module bca_time_core
   import bca_pkg::*;
#(
   parameter int DAY_W = 15
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      adv,
   input  logic [NUM_BCD-1:0]        bcd_wr,
   input  logic                      day_lo_wr,
   input  logic                      day_hi_wr,
   input  logic [7:0]                wdata,
   output logic [NUM_BCD-1:0][7:0]   bcd_cur,
   output logic [NUM_BCD-1:0][7:0]   bcd_nxt,
   output logic [DAY_W-1:0]          day_cur,
   output logic [DAY_W-1:0]          day_nxt
);
   localparam logic [NUM_BCD-1:0][7:0] LIMIT   = {8'h23, 8'h59, 8'h59};
   localparam logic [DAY_W-1:0]        DAY_MAX = '1;

   if (DAY_W < 9 || DAY_W > 16) begin : g_bad_day_w
      $error("bca_time_core: DAY_W must lie in 9..16");
   end

   logic [NUM_BCD:0] carry;
   assign carry[0] = 1'b1;

   for (genvar i = 0; i < NUM_BCD; i++) begin : g_bcd
      logic [7:0] q;
      logic       at_lim;
      assign at_lim       = (q == LIMIT[i]);
      assign carry[i+1]   = carry[i] & at_lim;
      assign bcd_nxt[i]   = !carry[i] ? q : (at_lim ? 8'h00 : bcd_step(q));
      assign bcd_cur[i]   = q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         q <= 8'h00;
         else if (bcd_wr[i]) q <= wdata;
         else if (adv)       q <= bcd_nxt[i];
      end
   end

   logic [DAY_W-1:0] day_q;
   assign day_nxt = carry[NUM_BCD] ? day_q + 1'b1 : day_q;
   assign day_cur = day_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         day_q <= '0;
      else if (day_lo_wr) day_q <= DAY_W'({day_q[DAY_W-1:8], wdata});
      else if (day_hi_wr) day_q <= DAY_W'({wdata, day_q[7:0]});
      else if (adv)       day_q <= day_nxt;
   end

   logic no_wr;
   assign no_wr = (bcd_wr == '0) && !day_lo_wr && !day_hi_wr;

   // R1
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && no_wr && bcd_cur[0] == 8'h59) |=> (bcd_cur[0] == 8'h00));

   // R2
   hour_day_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && no_wr && bcd_cur[2] == 8'h23 && bcd_cur[1] == 8'h59 &&
       bcd_cur[0] == 8'h59 && day_cur != DAY_MAX)
      |=> (day_cur == $past(day_cur) + 1'b1) && (bcd_cur[2] == 8'h00));

   // R3
   day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && no_wr && bcd_cur[2] == 8'h23 && bcd_cur[1] == 8'h59 &&
       bcd_cur[0] == 8'h59 && day_cur == DAY_MAX) |=> (day_cur == '0));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && no_wr) |=> ($stable(bcd_cur) && $stable(day_cur)));
endmodule

// File: rtl/bca_alarm.sv
module bca_alarm #(
   parameter int DAY_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eval,
   input  logic             wr_min,
   input  logic             wr_hour,
   input  logic             wr_dlo,
   input  logic             wr_dhi,
   input  logic [7:0]       wdata,
   input  logic             en_min,
   input  logic             en_hour,
   input  logic             en_day,
   input  logic             flag_clr,
   input  logic [7:0]       t_sec,
   input  logic [7:0]       t_min,
   input  logic [7:0]       t_hour,
   input  logic [DAY_W-1:0] t_day,
   output logic [7:0]       al_min,
   output logic [7:0]       al_hour,
   output logic [DAY_W-1:0] al_day,
   output logic             flag
);
   if (DAY_W < 9 || DAY_W > 16) begin : g_bad_day_w
      $error("bca_alarm: DAY_W must lie in 9..16");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         al_min  <= 8'h00;
         al_hour <= 8'h00;
         al_day  <= '0;
      end else begin
         if (wr_min)  al_min  <= wdata;
         if (wr_hour) al_hour <= wdata;
         if (wr_dlo)       al_day <= DAY_W'({al_day[DAY_W-1:8], wdata});
         else if (wr_dhi)  al_day <= DAY_W'({wdata, al_day[7:0]});
      end
   end

   logic m_min, m_hour, m_day, hit;
   assign m_min  = !en_min  || (t_min  == al_min);
   assign m_hour = !en_hour || (t_hour == al_hour);
   assign m_day  = !en_day  || (t_day  == al_day);
   assign hit    = eval && (t_sec == 8'h00) && m_min && m_hour && m_day;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (hit)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
   end

   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);

   // R9
   no_false_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && t_sec != 8'h00 && !flag) |=> !flag);
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import bca_pkg::*;
#(
   parameter int DAY_W  = 15,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq
);
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("bcd_rtc_core: ADDR_W must be at least 5");
   end

   logic run_q, ien_q, en_min_q, en_hour_q, en_day_q, busy_q;
   logic adv, busy, wr_ok, flag_clr, al_flag;

   assign adv   = tick & run_q;
   assign busy  = adv | busy_q;
   assign wr_ok = reg_wr & ~busy;

   function automatic logic sel(input logic [ADDR_W-1:0] a, input logic [7:0] r);
      sel = (a == ADDR_W'(r));
   endfunction

   logic wr_ctrl;
   assign wr_ctrl  = wr_ok && sel(reg_addr, A_CTRL);
   assign flag_clr = wr_ctrl && reg_wdata[B_FLAG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         ien_q     <= 1'b0;
         en_min_q  <= 1'b0;
         en_hour_q <= 1'b0;
         en_day_q  <= 1'b0;
         busy_q    <= 1'b0;
      end else begin
         busy_q <= adv;
         if (wr_ctrl) begin
            run_q     <= reg_wdata[B_RUN];
            ien_q     <= reg_wdata[B_IEN];
            en_min_q  <= reg_wdata[B_MNEN];
            en_hour_q <= reg_wdata[B_HREN];
            en_day_q  <= reg_wdata[B_DAYEN];
         end
      end
   end

   logic [NUM_BCD-1:0]      bcd_wr;
   logic [NUM_BCD-1:0][7:0] bcd_cur, bcd_nxt;
   logic [DAY_W-1:0]        day_cur, day_nxt;

   assign bcd_wr = {wr_ok && sel(reg_addr, A_HOUR),
                    wr_ok && sel(reg_addr, A_MIN),
                    wr_ok && sel(reg_addr, A_SEC)};

   bca_time_core #(.DAY_W(DAY_W)) u_time (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (adv),
      .bcd_wr    (bcd_wr),
      .day_lo_wr (wr_ok && sel(reg_addr, A_DAYLO)),
      .day_hi_wr (wr_ok && sel(reg_addr, A_DAYHI)),
      .wdata     (reg_wdata),
      .bcd_cur   (bcd_cur),
      .bcd_nxt   (bcd_nxt),
      .day_cur   (day_cur),
      .day_nxt   (day_nxt)
   );

   logic [7:0]       al_min, al_hour;
   logic [DAY_W-1:0] al_day;

   bca_alarm #(.DAY_W(DAY_W)) u_alarm (
      .clk      (clk),
      .rst_n    (rst_n),
      .eval     (adv),
      .wr_min   (wr_ok && sel(reg_addr, A_AMIN)),
      .wr_hour  (wr_ok && sel(reg_addr, A_AHOUR)),
      .wr_dlo   (wr_ok && sel(reg_addr, A_ADAYLO)),
      .wr_dhi   (wr_ok && sel(reg_addr, A_ADAYHI)),
      .wdata    (reg_wdata),
      .en_min   (en_min_q),
      .en_hour  (en_hour_q),
      .en_day   (en_day_q),
      .flag_clr (flag_clr),
      .t_sec    (bcd_nxt[0]),
      .t_min    (bcd_nxt[1]),
      .t_hour   (bcd_nxt[2]),
      .t_day    (day_nxt),
      .al_min   (al_min),
      .al_hour  (al_hour),
      .al_day   (al_day),
      .flag     (al_flag)
   );

   logic [15:0] day_ext, al_day_ext;
   assign day_ext    = 16'(day_cur);
   assign al_day_ext = 16'(al_day);

   always_comb begin
      reg_rdata = 8'h00;
      if (sel(reg_addr, A_CTRL))
         reg_rdata = {busy, 1'b0, en_day_q, en_hour_q, en_min_q, al_flag, ien_q, run_q};
      else if (sel(reg_addr, A_SEC))    reg_rdata = bcd_cur[0];
      else if (sel(reg_addr, A_MIN))    reg_rdata = bcd_cur[1];
      else if (sel(reg_addr, A_HOUR))   reg_rdata = bcd_cur[2];
      else if (sel(reg_addr, A_DAYLO))  reg_rdata = day_ext[7:0];
      else if (sel(reg_addr, A_DAYHI))  reg_rdata = day_ext[15:8];
      else if (sel(reg_addr, A_AMIN))   reg_rdata = al_min;
      else if (sel(reg_addr, A_AHOUR))  reg_rdata = al_hour;
      else if (sel(reg_addr, A_ADAYLO)) reg_rdata = al_day_ext[7:0];
      else if (sel(reg_addr, A_ADAYHI)) reg_rdata = al_day_ext[15:8];
   end

   assign irq = al_flag & ien_q;

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> busy);

   // R8
   wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !adv && reg_wr && sel(reg_addr, A_MIN)) |=> $stable(bcd_cur[1]));
endmodule

// File: tb/bcd_rtc_core_bench.sv
`timescale 1ns/1ps
module bcd_rtc_core_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   bcd_rtc_core u_bcd_rtc_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   // reference model state
   logic [7:0]  m_sec, m_min, m_hr, m_amin, m_ahr;
   logic [14:0] m_day, m_aday;
   logic        m_run, m_ien, m_emin, m_ehr, m_eday, m_flag;

   function automatic logic [7:0] to_bcd(input int b);
      return 8'(((b / 10) * 16) + (b % 10));
   endfunction

   function automatic int from_bcd(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] a);
      case (a)
         8'h14: return {2'b00, m_eday, m_ehr, m_emin, m_flag, m_ien, m_run};
         8'h15: return m_sec;
         8'h16: return m_min;
         8'h17: return m_hr;
         8'h18: return m_day[7:0];
         8'h19: return {1'b0, m_day[14:8]};
         8'h1A: return m_amin;
         8'h1B: return m_ahr;
         8'h1C: return m_aday[7:0];
         8'h1D: return {1'b0, m_aday[14:8]};
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_reset();
      m_sec = 0; m_min = 0; m_hr = 0; m_amin = 0; m_ahr = 0;
      m_day = 0; m_aday = 0;
      m_run = 0; m_ien = 0; m_emin = 0; m_ehr = 0; m_eday = 0; m_flag = 0;
   endtask

   task automatic model_tick();
      int s, mi, h;
      if (m_run) begin
         s  = from_bcd(m_sec) + 1;
         mi = from_bcd(m_min);
         h  = from_bcd(m_hr);
         if (s == 60) begin s = 0; mi = mi + 1; end
         if (mi == 60) begin mi = 0; h = h + 1; end
         if (h == 24) begin h = 0; m_day = m_day + 15'd1; end
         m_sec = to_bcd(s); m_min = to_bcd(mi); m_hr = to_bcd(h);
         if (m_sec == 8'h00 && (!m_emin || m_min == m_amin) &&
             (!m_ehr || m_hr == m_ahr) && (!m_eday || m_day == m_aday))
            m_flag = 1'b1;
      end
   endtask

   task automatic model_write(input logic [7:0] a, input logic [7:0] d);
      case (a)
         8'h14: begin
            m_run = d[0]; m_ien = d[1]; m_emin = d[3]; m_ehr = d[4]; m_eday = d[5];
            if (d[2]) m_flag = 1'b0;
         end
         8'h15: m_sec = d;
         8'h16: m_min = d;
         8'h17: m_hr = d;
         8'h18: m_day[7:0] = d;
         8'h19: m_day[14:8] = d[6:0];
         8'h1A: m_amin = d;
         8'h1B: m_ahr = d;
         8'h1C: m_aday[7:0] = d;
         8'h1D: m_aday[14:8] = d[6:0];
         default: ;
      endcase
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a);
      @(negedge clk);
      reg_addr = a;
      #1 chk(req, reg_rdata, exp_read(a));
   endtask

   task automatic do_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      model_tick();
   endtask

   task automatic set_time(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                           input logic [14:0] d);
      do_write(8'h15, s);
      do_write(8'h16, mi);
      do_write(8'h17, h);
      do_write(8'h18, d[7:0]);
      do_write(8'h19, {1'b0, d[14:8]});
   endtask

   task automatic irq_chk(input string req);
      @(negedge clk);
      #1 chk(req, irq, m_flag & m_ien);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      int unsigned seed_dummy;
      logic [7:0] d;
      model_reset();
      seed_dummy = $urandom(32'd5813);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd_chk("R4 reset seconds", 8'h15);
      rd_chk("R6 reset control", 8'h14);
      rd_chk("R4 reset day high", 8'h19);
      irq_chk("R10 reset irq");

      // run off: ticks ignored
      do_write(8'h15, 8'h58);
      do_tick();
      rd_chk("R5 no advance while run=0", 8'h15);
      @(negedge clk); reg_addr = 8'h14; tick = 1'b1;
      #1 chk("R7 no busy with run=0", reg_rdata[7], 1'b0);
      @(negedge clk); tick = 1'b0;

      // run on
      do_write(8'h14, 8'h01);
      do_tick();
      rd_chk("R5 advance with run=1", 8'h15);
      do_tick();
      rd_chk("R1 seconds wrap to 00", 8'h15);
      rd_chk("R1 minute carry", 8'h16);

      // day carry across byte boundary
      set_time(8'h23, 8'h59, 8'h59, 15'h00FF);
      do_tick();
      rd_chk("R2 hours wrap", 8'h17);
      rd_chk("R2 day low after carry", 8'h18);
      rd_chk("R3 day high after carry", 8'h19);

      // day wrap at maximum
      set_time(8'h23, 8'h59, 8'h59, 15'h7FFF);
      do_write(8'h19, 8'hFF);
      rd_chk("R4 day high bit7 dropped", 8'h19);
      do_tick();
      rd_chk("R3 day low wraps", 8'h18);
      rd_chk("R3 day high wraps", 8'h19);
      rd_chk("R1 minutes after full wrap", 8'h16);
      rd_chk("R4 unmapped address", 8'h30);

      // busy and write drop in tick cycle
      set_time(8'h05, 8'h10, 8'h20, 15'd3);
      @(negedge clk);
      tick = 1'b1; reg_addr = 8'h15; reg_wdata = 8'h33; reg_wr = 1'b1;
      @(negedge clk);
      tick = 1'b0; reg_wr = 1'b0; reg_addr = 8'h14;
      model_tick();
      #1 chk("R7 busy cycle after tick", reg_rdata[7], 1'b1);
      @(negedge clk);
      #1 chk("R7 busy released", reg_rdata[7], 1'b0);
      rd_chk("R8 write in tick cycle dropped", 8'h15);

      // busy seen in tick cycle; write in following cycle dropped
      @(negedge clk);
      tick = 1'b1; reg_addr = 8'h14;
      #1 chk("R7 busy in tick cycle", reg_rdata[7], 1'b1);
      @(negedge clk);
      tick = 1'b0; reg_addr = 8'h16; reg_wdata = 8'h44; reg_wr = 1'b1;
      model_tick();
      @(negedge clk);
      reg_wr = 1'b0;
      rd_chk("R8 write in cycle after tick dropped", 8'h16);

      // alarm full match
      do_write(8'h1A, 8'h30);
      do_write(8'h1B, 8'h10);
      do_write(8'h1C, 8'h05);
      do_write(8'h1D, 8'h00);
      do_write(8'h14, 8'h3B);
      set_time(8'h10, 8'h29, 8'h58, 15'd5);
      do_tick();
      rd_chk("R9 no flag at non-zero seconds", 8'h14);
      do_tick();
      rd_chk("R9 flag on full match", 8'h14);
      irq_chk("R10 irq with enable");
      do_write(8'h14, 8'h3B);
      rd_chk("R6 write 0 to flag keeps it", 8'h14);
      do_write(8'h14, 8'h3F);
      rd_chk("R6 write 1 clears flag", 8'h14);
      irq_chk("R10 irq low after clear");

      // day mismatch blocks, then day compare disabled allows
      set_time(8'h10, 8'h29, 8'h59, 15'd6);
      do_tick();
      rd_chk("R9 day mismatch no flag", 8'h14);
      do_write(8'h14, 8'h1B);
      set_time(8'h10, 8'h29, 8'h59, 15'd6);
      do_tick();
      rd_chk("R9 day compare off gives flag", 8'h14);
      do_write(8'h14, 8'h1D);
      set_time(8'h10, 8'h29, 8'h59, 15'd9);
      do_tick();
      rd_chk("R9 flag with interrupt disabled", 8'h14);
      irq_chk("R10 irq masked");

      // constrained random
      for (int it = 0; it < 600; it++) begin
         int op, f;
         op = int'($urandom % 10);
         if (op <= 5) begin
            do_tick();
         end else if (op == 6) begin
            f = int'($urandom % 9);
            case (f)
               0, 1, 5: d = ($urandom % 2) ? 8'h59 : to_bcd(int'($urandom % 60));
               2, 6:    d = ($urandom % 2) ? 8'h23 : to_bcd(int'($urandom % 24));
               3, 7:    d = ($urandom % 2) ? 8'hFF : 8'($urandom);
               default: d = ($urandom % 2) ? 8'h7F : 8'($urandom);
            endcase
            do_write(8'(8'h15 + f), d);
         end else if (op == 7) begin
            rd_chk("R1 R2 R3 random field readback", 8'(8'h15 + ($urandom % 9)));
         end else if (op == 8) begin
            d = 8'($urandom);
            d[0] = (($urandom % 8) != 0);
            do_write(8'h14, d);
         end else begin
            rd_chk("R6 R9 random control readback", 8'h14);
            irq_chk("R10 random irq");
         end
      end

      for (int a = 8'h14; a <= 8'h1D; a++)
         rd_chk("R4 final register sweep", 8'(a));

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule